// File: doc/BRIEF.md
# Four-Axis Game Port Counter

This block times four joystick axes. Each axis has a one-shot whose output stays high for a time that depends on the stick position. The block gives each axis its own 16-bit counter. A trigger clears every enabled counter and starts it. While its axis input stays high, a counter advances on each selected tick. It stops for good when the input is seen low. Once every enabled counter has stopped, a ready flag is set, and if enabled it raises the interrupt output.

Software sets up the block through one 8-bit setup/status register. It collects the results from a single 8-bit count port, which hands out each enabled axis's count as high byte then low byte and steps onward by itself on every read. A trigger can come from a dedicated start strobe, or from a game-port write strobe when auto-trigger is enabled. Ticks come from two external strobes: a normal slow rate and a fast test rate.

Top module: `gameport_counter`

## Requirements
- R1: After reset, the setup register reads 00h, the interrupt output is low, and the count port reads 00h.
- R2: The setup register has these fields: bits 3:0 are axis enables (bit 0 first-stick X, bit 1 first-stick Y, bit 2 second-stick X, bit 3 second-stick Y), bit 4 is auto-trigger enable, bit 5 is interrupt enable, and bit 7 is the ready flag, which is read-only. Bit 6 always reads 0, and the written fields read back as written.
- R3: A trigger is `start_i`, or `gp_wr_i` while auto-trigger is set. `gp_wr_i` is ignored while auto-trigger is clear. On a trigger, each enabled counter is cleared to 0 and starts running. Disabled counters keep their value.
- R4: At each clock edge, a running counter whose axis input is high increments by one if the selected tick is high. At the first edge where its axis input is low, the counter stops and does not increment.
- R5: `test_fast_i`=1 selects `fast_tick_i` as the counting tick. Otherwise `slow_tick_i` is used.
- R6: A counter holds at FFFFh instead of wrapping.
- R7: The ready flag is set one clock after the last enabled counter stops. If no axis is enabled, it is set at the trigger edge itself.
- R8: A trigger clears the ready flag. A setup write with bit 7 set also clears it, but a ready set in the same cycle takes priority over that write.
- R9: `irq_o` is high exactly when both the ready flag and the interrupt enable are set.
- R10: The count port shows the high byte and then the low byte of the selected axis. Axes are visited in ascending order, skipping disabled ones and wrapping around. Each cycle with `cnt_rd_i` high moves to the next byte.
- R11: A trigger or a setup write points the readout at the lowest enabled axis, high byte. With no axis enabled, the count port reads 00h and reads do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Setup register write strobe |
| cfg_wdata_i | input | 8 | Setup register write data |
| cfg_rdata_o | output | 8 | Setup/status readback |
| cnt_rd_i | input | 1 | Count port read strobe, advances the readout |
| cnt_rdata_o | output | 8 | Current count byte |
| start_i | input | 1 | Direct trigger strobe |
| gp_wr_i | input | 1 | Game-port write strobe, a trigger when auto-trigger is set |
| axis_i | input | 4 | Axis one-shot levels, bit order as the enables |
| slow_tick_i | input | 1 | Normal-rate count tick |
| fast_tick_i | input | 1 | Test-rate count tick |
| test_fast_i | input | 1 | Selects the test-rate tick |
| irq_o | output | 1 | Interrupt output |

## Verification
All four axes are run with different release times, so every count differs from the others. This exposes a swapped axis or a swapped byte in the readout. A masked run with two enables, read past the wrap, separates skipping from plain stepping. A later full read shows that the masked counters kept their old values. A fast-tick run held for a known number of cycles gives an exact count, which tells the tick select apart from the slow path. A run held past 65535 ticks shows saturation rather than wrap. A run with no enables, and a game-port write made with auto-trigger off and then on, probe the two trigger sources and the immediate-ready path.

// File: rtl/gp_pkg.sv
package gp_pkg;

    localparam int NAX = 4;
    localparam int AXW = $clog2(NAX);
    localparam int CW  = 16;

    // setup/status register layout, bit 7 down to bit 0
    typedef struct packed {
        logic           ready;
        logic           rsvd;
        logic           irq_en;
        logic           auto_en;
        logic [NAX-1:0] en;
    } cfg_t;

    // readout pointer: which axis, and whether the low byte is next
    typedef struct packed {
        logic [AXW-1:0] axis;
        logic           lo;
    } rdptr_t;

    // next enabled axis after cur, wrapping; cur itself if it is the only one
    function automatic logic [AXW-1:0] pick_next(input logic [NAX-1:0] en,
                                                 input logic [AXW-1:0] cur);
        logic [AXW-1:0] res;
        int             idx;
        res = cur;
        for (int k = NAX; k >= 1; k--) begin
            idx = (int'(cur) + k) % NAX;
            if (en[idx]) res = AXW'(idx);
        end
        return res;
    endfunction

endpackage

// File: rtl/gp_axis_counter.sv
module gp_axis_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             axis_i,
    output logic [CNT_W-1:0] count_o,
    output logic             run_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            run_q <= en_i;
            if (en_i) cnt_q <= '0;
        end else if (run_q) begin
            if (!axis_i) begin
                run_q <= 1'b0;
            end else if (tick_i && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign count_o = cnt_q;
    assign run_o   = run_q;

endmodule

// File: rtl/gp_ctrl.sv
module gp_ctrl
    import gp_pkg::*;
#(
    parameter int N_AX = NAX
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr_i,
    input  logic [7:0]      cfg_wdata_i,
    input  logic            start_i,
    input  logic            gp_wr_i,
    input  logic [N_AX-1:0] running_i,
    output logic            trig_o,
    output logic [N_AX-1:0] en_o,
    output logic [N_AX-1:0] en_nxt_o,
    output logic            busy_o,
    output logic [7:0]      cfg_rdata_o,
    output logic            irq_o
);

    cfg_t cfg_q;
    cfg_t cfg_w;
    logic busy_q;

    assign cfg_w  = cfg_t'(cfg_wdata_i);
    assign trig_o = start_i | (gp_wr_i & cfg_q.auto_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            if (cfg_wr_i) begin
                cfg_q.en      <= cfg_w.en;
                cfg_q.auto_en <= cfg_w.auto_en;
                cfg_q.irq_en  <= cfg_w.irq_en;
            end
            if (trig_o) begin
                cfg_q.ready <= (cfg_q.en == '0);
                busy_q      <= (cfg_q.en != '0);
            end else if (busy_q && running_i == '0) begin
                cfg_q.ready <= 1'b1;
                busy_q      <= 1'b0;
            end else if (cfg_wr_i && cfg_w.ready) begin
                cfg_q.ready <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rdata_o    = cfg_q;
        cfg_rdata_o[6] = 1'b0;
    end

    assign en_o     = cfg_q.en;
    assign en_nxt_o = cfg_wr_i ? cfg_w.en : cfg_q.en;
    assign busy_o   = busy_q;
    assign irq_o    = cfg_q.ready & cfg_q.irq_en;

endmodule

// File: rtl/gp_readout.sv
module gp_readout
    import gp_pkg::*;
#(
    parameter int N_AX  = NAX,
    parameter int CNT_W = CW
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       trig_i,
    input  logic                       cfg_wr_i,
    input  logic                       rd_i,
    input  logic [N_AX-1:0]            en_i,
    input  logic [N_AX-1:0]            en_nxt_i,
    input  logic [N_AX-1:0][CNT_W-1:0] counts_i,
    output rdptr_t                     ptr_o,
    output logic [7:0]                 rdata_o
);

    localparam logic [AXW-1:0] LAST_AX = AXW'(N_AX - 1);

    rdptr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (trig_i || cfg_wr_i) begin
            ptr_q.axis <= pick_next(en_nxt_i, LAST_AX);
            ptr_q.lo   <= 1'b0;
        end else if (rd_i && en_i != '0) begin
            if (!ptr_q.lo) begin
                ptr_q.lo <= 1'b1;
            end else begin
                ptr_q.lo   <= 1'b0;
                ptr_q.axis <= pick_next(en_i, ptr_q.axis);
            end
        end
    end

    always_comb begin
        if (en_i == '0)     rdata_o = 8'h00;
        else if (ptr_q.lo)  rdata_o = counts_i[ptr_q.axis][7:0];
        else                rdata_o = counts_i[ptr_q.axis][CNT_W-1:8];
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/gameport_counter.sv
module gameport_counter
    import gp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o,
    input  logic       cnt_rd_i,
    output logic [7:0] cnt_rdata_o,
    input  logic       start_i,
    input  logic       gp_wr_i,
    input  logic [3:0] axis_i,
    input  logic       slow_tick_i,
    input  logic       fast_tick_i,
    input  logic       test_fast_i,
    output logic       irq_o
);

    logic                    trig;
    logic                    tick;
    logic                    busy;
    logic [NAX-1:0]          en;
    logic [NAX-1:0]          en_nxt;
    logic [NAX-1:0]          running;
    logic [NAX-1:0][CW-1:0]  counts;
    rdptr_t                  rd_ptr;

    assign tick = test_fast_i ? fast_tick_i : slow_tick_i;

    gp_ctrl #(.N_AX(NAX)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_wdata_i(cfg_wdata_i),
        .start_i    (start_i),
        .gp_wr_i    (gp_wr_i),
        .running_i  (running),
        .trig_o     (trig),
        .en_o       (en),
        .en_nxt_o   (en_nxt),
        .busy_o     (busy),
        .cfg_rdata_o(cfg_rdata_o),
        .irq_o      (irq_o)
    );

    for (genvar i = 0; i < NAX; i++) begin : g_axis
        gp_axis_counter #(.CNT_W(CW)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .start_i(trig),
            .en_i   (en[i]),
            .tick_i (tick),
            .axis_i (axis_i[i]),
            .count_o(counts[i]),
            .run_o  (running[i])
        );
    end

    gp_readout #(.N_AX(NAX), .CNT_W(CW)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig),
        .cfg_wr_i(cfg_wr_i),
        .rd_i    (cnt_rd_i),
        .en_i    (en),
        .en_nxt_i(en_nxt),
        .counts_i(counts),
        .ptr_o   (rd_ptr),
        .rdata_o (cnt_rdata_o)
    );

endmodule

// File: rtl/gameport_counter_chk.sv
module gameport_counter_chk
    import gp_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   trig,
    input logic                   cfg_wr_i,
    input logic [7:0]             cfg_wdata_i,
    input logic                   cnt_rd_i,
    input logic                   busy,
    input logic                   ready,
    input logic [NAX-1:0]         en,
    input logic [NAX-1:0]         running,
    input logic [NAX-1:0][CW-1:0] counts,
    input rdptr_t                 rd_ptr
);

    localparam logic [CW-1:0] FULL = '1;

    for (genvar i = 0; i < NAX; i++) begin : g_ax
        a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
            (trig && en[i]) |=> (counts[i] == '0 && running[i]));
        a_r4_step_by_one: assert property (@(posedge clk) disable iff (rst)
            (!trig && running[i]) |=>
                (counts[i] == $past(counts[i]) || counts[i] == $past(counts[i]) + 1'b1));
        a_r4_stopped_hold: assert property (@(posedge clk) disable iff (rst)
            (!trig && !running[i]) |=> $stable(counts[i]));
        a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
            (!trig && counts[i] == FULL) |=> counts[i] == FULL);
    end

    a_r7_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> running == '0);

    a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_i && cfg_wdata_i[7] && !trig && !busy) |=> !ready);

    a_r10_hi_then_lo: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd_i && en != '0 && !trig && !cfg_wr_i && !rd_ptr.lo) |=>
            (rd_ptr.lo && $stable(rd_ptr.axis)));

    a_r10_on_enabled: assert property (@(posedge clk) disable iff (rst)
        (en != '0) |-> en[rd_ptr.axis]);

    a_r11_empty_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd_i && en == '0 && !trig && !cfg_wr_i) |=> $stable(rd_ptr));

endmodule

bind gameport_counter gameport_counter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cnt_rd_i   (cnt_rd_i),
    .busy       (busy),
    .ready      (cfg_rdata_o[7]),
    .en         (en),
    .running    (running),
    .counts     (counts),
    .rd_ptr     (rd_ptr)
);

// File: tb/gameport_counter_tb.sv
module gameport_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       cnt_rd = 1'b0;
    logic [7:0] cnt_rdata;
    logic       start = 1'b0;
    logic       gp_wr = 1'b0;
    logic [3:0] axis = 4'h0;
    logic       slow_tick = 1'b0;
    logic       fast_tick = 1'b1;
    logic       test_fast = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_ctr = 0;

    // reference model state
    int m_cnt[4];
    bit m_run[4];
    int m_en, m_auto, m_irqen, m_ready, m_busy, m_pax, m_plo;

    always #10 clk = ~clk;

    gameport_counter u_dut (
        .clk(clk), .rst(rst),
        .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
        .cnt_rd_i(cnt_rd), .cnt_rdata_o(cnt_rdata),
        .start_i(start), .gp_wr_i(gp_wr), .axis_i(axis),
        .slow_tick_i(slow_tick), .fast_tick_i(fast_tick), .test_fast_i(test_fast),
        .irq_o(irq)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int m_first(int e);
        for (int i = 0; i < 4; i++) if (e[i]) return i;
        return 0;
    endfunction

    function automatic int m_next(int e, int cur);
        for (int k = 1; k <= 4; k++) if (e[(cur + k) % 4]) return (cur + k) % 4;
        return cur;
    endfunction

    function automatic int exp_cfg();
        return (m_ready << 7) | (m_irqen << 5) | (m_auto << 4) | m_en;
    endfunction

    function automatic int exp_byte();
        if (m_en == 0) return 0;
        return m_plo ? (m_cnt[m_pax] & 255) : (m_cnt[m_pax] >> 8);
    endfunction

    // model update on every edge, from the inputs held across it
    always @(posedge clk) begin
        int  trig, tick, anyrun, en_after;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_run[i] = 0; end
            m_en = 0; m_auto = 0; m_irqen = 0; m_ready = 0; m_busy = 0;
            m_pax = 0; m_plo = 0;
        end else begin
            trig     = (start || (gp_wr && m_auto != 0)) ? 1 : 0;
            tick     = test_fast ? int'(fast_tick) : int'(slow_tick);
            anyrun   = 0;
            for (int i = 0; i < 4; i++) if (m_run[i]) anyrun = 1;
            en_after = cfg_wr ? int'(cfg_wdata[3:0]) : m_en;
            for (int i = 0; i < 4; i++) begin
                if (trig != 0) begin
                    m_run[i] = m_en[i];
                    if (m_en[i]) m_cnt[i] = 0;
                end else if (m_run[i]) begin
                    if (!axis[i]) m_run[i] = 0;
                    else if (tick != 0 && m_cnt[i] < 65535) m_cnt[i]++;
                end
            end
            if (trig != 0) begin
                m_ready = (m_en == 0); m_busy = (m_en != 0);
            end else if (m_busy != 0 && anyrun == 0) begin
                m_ready = 1; m_busy = 0;
            end else if (cfg_wr && cfg_wdata[7]) begin
                m_ready = 0;
            end
            if (trig != 0 || cfg_wr) begin
                m_pax = m_first(en_after); m_plo = 0;
            end else if (cnt_rd && m_en != 0) begin
                if (m_plo == 0) m_plo = 1;
                else begin m_plo = 0; m_pax = m_next(m_en, m_pax); end
            end
            if (cfg_wr) begin
                m_en = cfg_wdata[3:0]; m_auto = cfg_wdata[4]; m_irqen = cfg_wdata[5];
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 setup readback", cfg_rdata, exp_cfg());
            chk("R9 interrupt", irq, m_ready & m_irqen);
            chk("R10 count byte", cnt_rdata, exp_byte());
        end
    end

    always @(posedge clk) begin
        #1;
        tick_ctr++;
        slow_tick = (tick_ctr % 3 == 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr_cfg(int v);
        cfg_wr = 1'b1; cfg_wdata = 8'(v); step(); cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; step(); start = 1'b0;
    endtask

    task automatic rd_byte(output int b);
        b = cnt_rdata; cnt_rd = 1'b1; step(); cnt_rd = 1'b0;
    endtask

    task automatic rd_word(output int w);
        int hi, lo;
        rd_byte(hi); rd_byte(lo); w = (hi << 8) | lo;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!cfg_rdata[7] && n < 2000) begin step(); n++; end
    endtask

    initial begin
        int w, saved_ay;
        step(3);
        rst = 1'b0;
        step();
        chk("R1 reset setup", cfg_rdata, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset count", cnt_rdata, 0);

        // all four axes, slow tick, distinct release times
        wr_cfg(8'h2F);
        chk("R2 fields", cfg_rdata, 8'h2F);
        axis = 4'hF;
        pulse_start();
        step(20); axis[0] = 1'b0;
        step(17); axis[3] = 1'b0;
        step(30); axis[2] = 1'b0;
        step(9);  axis[1] = 1'b0;
        wait_ready();
        chk("R7 ready after stop", cfg_rdata[7], 1);
        chk("R9 irq raised", irq, 1);
        rd_word(w); chk("R4 first X count", w, m_cnt[0]);
        rd_word(w); saved_ay = w; chk("R4 first Y count", w, m_cnt[1]);
        rd_word(w); chk("R10 second X", w, m_cnt[2]);
        rd_word(w); chk("R10 second Y", w, m_cnt[3]);
        rd_word(w); chk("R10 wrap to first", w, m_cnt[0]);

        // clear by writing 1 to the ready bit
        wr_cfg(8'hAF);
        chk("R8 ready cleared", cfg_rdata[7], 0);
        chk("R8 irq dropped", irq, 0);

        // masked run: only first-stick X and second-stick X
        wr_cfg(8'h05);
        axis = 4'hF;
        pulse_start();
        step(12); axis = 4'h0;
        wait_ready();
        for (int k = 0; k < 6; k++) rd_byte(w);
        wr_cfg(8'h0F);
        rd_byte(w);
        rd_byte(w);
        rd_word(w); chk("R3 disabled count kept", w, saved_ay);

        // pointer reset by a setup write mid-word
        rd_byte(w);
        wr_cfg(8'h0F);
        chk("R11 pointer at first high", cnt_rdata, m_cnt[0] >> 8);

        // game-port write ignored with auto-trigger clear
        wr_cfg(8'h8F);
        axis = 4'h0;
        gp_wr = 1'b1; step(); gp_wr = 1'b0;
        step(6);
        chk("R3 game write ignored", cfg_rdata[7], 0);
        wr_cfg(8'h1F);
        gp_wr = 1'b1; step(); gp_wr = 1'b0;
        step(6);
        chk("R3 game write triggers", cfg_rdata[7], 1);

        // no axis enabled
        wr_cfg(8'hA0);
        pulse_start();
        chk("R7 ready at trigger", cfg_rdata[7], 1);
        chk("R11 empty reads zero", cnt_rdata, 0);
        rd_byte(w);
        chk("R11 empty stays zero", cnt_rdata, 0);

        // fast tick, held exactly 40 edges
        wr_cfg(8'h81);
        test_fast = 1'b1;
        axis = 4'h1;
        pulse_start();
        step(40); axis = 4'h0;
        wait_ready();
        rd_word(w); chk("R5 fast count", w, 40);

        // saturation on second-stick Y
        wr_cfg(8'h88);
        axis = 4'h8;
        pulse_start();
        step(65600); axis = 4'h0;
        wait_ready();
        rd_byte(w); chk("R6 saturated high", w, 8'hFF);
        rd_byte(w); chk("R6 saturated low", w, 8'hFF);
        test_fast = 1'b0;
        step(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule